// File: doc/BRIEF.md
# Hub Downstream Port Power Controller

This block switches the supply to the downstream ports of a USB 2.0 hub and watches the overcurrent flags that come back from the external power switches. Hub request logic sends it single-cycle commands. Each command carries a port index and one of three operations: turn power on, turn power off, or acknowledge an overcurrent change. The block drives one enable per port. It filters each incoming flag, cuts power to a port when a sustained overcurrent appears, and keeps the status bits and change bits that the hub reports to the host.

A static mode input sets how far one fault reaches. In per-port mode every port has its own enable and flag, and a fault on one port leaves the other ports untouched. In shared mode only the first port's enable and flag pins are used. Power for all ports is switched as one unit, and a fault is recorded at hub level. A read port returns the 16-bit status word and the 16-bit change word for a selected port. A bitmap output (hub in bit 0, port n in bit n+1) tells the interrupt endpoint logic which changes are pending.

Top module: `hub_port_power`

## Requirements
- R1: After reset every enable output is low, every status and change bit reads zero, and the status-change bitmap is zero.
- R2: A power-on command (op code 1) drives the addressed enable high on the clock edge that samples it. A power-off command (op code 2) drives it low. Op code 0 does nothing. Status word bit 8 reflects the power state of the port.
- R3: In per-port mode (mode input high), commands and faults on one port change no other port's enable, status or change bits.
- R4: In shared mode (mode input low), power commands to any port index control enable 0. Enables 1 to NUM_PORTS-1 stay low, and the flags of those ports have no effect.
- R5: A flag held low for no more than (FILT_LEN-1)*TICK_DIV clock cycles does not count as an overcurrent.
- R6: A flag held low keeps a powered enable high for at least 2+(FILT_LEN-1)*TICK_DIV cycles. It brings the enable low within FILT_LEN*TICK_DIV+4 cycles.
- R7: In per-port mode, a detected overcurrent sets status bit 3 and change bit 3 of that port, clears its power bit, and raises bitmap bit n+1.
- R8: In shared mode, a detected overcurrent sets the hub overcurrent status and hub change outputs and raises bitmap bit 0. Port status bit 3 and change bit 3 stay zero.
- R9: A power-on command is refused while the port's flag is seen low (held for at least two cycles), so the enable stays low.
- R10: An overcurrent status bit clears once the flag is high again and the port is unpowered. The change bit stays set until an acknowledge command (op code 3) reaches the same port. In shared mode, an acknowledge with any port index clears the hub change bit.
- R11: All bits of the status and change words other than those named in R2 and R7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| indiv_mode | input | 1 | 1: per-port control, 0: shared control through port 0 |
| req_valid | input | 1 | Command strobe, one cycle |
| req_op | input | 2 | 0 none, 1 power on, 2 power off, 3 acknowledge overcurrent change |
| req_port | input | $clog2(NUM_PORTS) | Port index of the command |
| oc_flag_n | input | NUM_PORTS | Overcurrent flags from the switches, low means overcurrent |
| vbus_en | output | NUM_PORTS | Supply enables, high means power on |
| rd_port | input | $clog2(NUM_PORTS) | Port selected for the status read |
| rd_status | output | 16 | Status word of the selected port |
| rd_change | output | 16 | Change word of the selected port |
| hub_oc_status | output | 1 | Hub-level overcurrent status (shared mode) |
| hub_oc_change | output | 1 | Hub-level overcurrent change (shared mode) |
| status_change | output | NUM_PORTS+1 | Pending changes: bit 0 hub, bit n+1 port n |

## Verification
The bench builds the block with four ports, a tick every 4 clocks and a filter length of 3 ticks. The whole detection window is then about a dozen cycles. At that size the bench can test both edges of R6 exactly, along with a glitch one tick shorter than the filter. It can also sweep all 16 power masks and inject a fault on every port in turn. The same small build runs again in shared mode, where the faults on ports 1 to 3 are shown to have no effect.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_PWR_ON  = 2'd1,
        OP_PWR_OFF = 2'd2,
        OP_ACK_OC  = 2'd3
    } hpp_op_e;

    localparam int WORD_W      = 16;
    localparam int ST_OC_BIT   = 3;
    localparam int ST_PWR_BIT  = 8;
    localparam int CHG_OC_BIT  = 3;

    typedef struct packed {
        logic pwr;
        logic oc_st;
        logic oc_chg;
    } port_state_t;

    function automatic logic [WORD_W-1:0] pack_status(input logic pwr, input logic oc);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ST_PWR_BIT] = pwr;
        w[ST_OC_BIT]  = oc;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_change(input logic oc_chg);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CHG_OC_BIT] = oc_chg;
        return w;
    endfunction

endpackage

// File: rtl/hpp_tick_gen.sv
module hpp_tick_gen #(
    parameter int TICK_DIV = 60
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) cnt <= '0;
                else if (cnt == CW'(TICK_DIV - 1)) cnt <= '0;
                else cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(TICK_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/hpp_flag_filter.sv
module hpp_flag_filter #(
    parameter int FILT_LEN = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic flag_n,
    output logic lo_sync,
    output logic oc_lvl
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic s1, s2;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= flag_n;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else if (s2) run <= '0;
        else if (tick && run != CW'(FILT_LEN)) run <= run + 1'b1;
    end

    assign lo_sync = ~s2;
    assign oc_lvl  = (run == CW'(FILT_LEN));

    // R5
    fault_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_lvl) |-> $past(~s2));
endmodule

// File: rtl/hpp_port_ctrl.sv
module hpp_port_ctrl
    import hpp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        act,
    input  logic        set_req,
    input  logic        clr_req,
    input  logic        ack_req,
    input  logic        flag_lo,
    input  logic        oc_lvl,
    output port_state_t st
);
    logic oc_lvl_q;
    logic oc_rise;

    assign oc_rise = act & oc_lvl & ~oc_lvl_q;

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            st       <= '0;
            oc_lvl_q <= 1'b0;
        end else begin
            oc_lvl_q <= oc_lvl;
            if (oc_rise)                  st.pwr <= 1'b0;
            else if (clr_req)             st.pwr <= 1'b0;
            else if (set_req && !flag_lo) st.pwr <= 1'b1;

            if (oc_rise)                  st.oc_st <= 1'b1;
            else if (!oc_lvl && !st.pwr)  st.oc_st <= 1'b0;

            if (oc_rise)                  st.oc_chg <= 1'b1;
            else if (ack_req)             st.oc_chg <= 1'b0;
        end
    end

    // R9
    no_power_into_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (act && set_req && flag_lo && !st.pwr) |=> !st.pwr);

    // R7
    fault_cuts_power_chk: assert property (@(posedge clk) disable iff (rst)
        (oc_rise && act) |=> (!st.pwr && st.oc_st && st.oc_chg));

    // R10
    change_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (act && st.oc_chg && !ack_req) |=> st.oc_chg);
endmodule

// File: rtl/hub_port_power.sv
module hub_port_power
    import hpp_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int TICK_DIV  = 60,
    parameter int FILT_LEN  = 1000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         indiv_mode,
    input  logic                         req_valid,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(NUM_PORTS)-1:0] req_port,
    input  logic [NUM_PORTS-1:0]         oc_flag_n,
    output logic [NUM_PORTS-1:0]         vbus_en,
    input  logic [$clog2(NUM_PORTS)-1:0] rd_port,
    output logic [15:0]                  rd_status,
    output logic [15:0]                  rd_change,
    output logic                         hub_oc_status,
    output logic                         hub_oc_change,
    output logic [NUM_PORTS:0]           status_change
);
    localparam int PIDX_W     = $clog2(NUM_PORTS);
    localparam int SHUT_BOUND = FILT_LEN * TICK_DIV + 4;
    localparam int SCW        = $clog2(SHUT_BOUND + 2);

    hpp_op_e op;
    assign op = hpp_op_e'(req_op);

    logic tick;
    logic [NUM_PORTS-1:0] lo_sync, oc_lvl;
    port_state_t          pst [NUM_PORTS];
    port_state_t          hst;

    hpp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_PORTS; i++) begin : g_port
            logic hit;
            assign hit = req_valid && indiv_mode && (req_port == PIDX_W'(i));

            hpp_flag_filter #(.FILT_LEN(FILT_LEN)) u_filt (
                .clk(clk), .rst(rst), .tick(tick),
                .flag_n(oc_flag_n[i]),
                .lo_sync(lo_sync[i]), .oc_lvl(oc_lvl[i])
            );

            hpp_port_ctrl u_ctrl (
                .clk(clk), .rst(rst), .act(indiv_mode),
                .set_req(hit && op == OP_PWR_ON),
                .clr_req(hit && op == OP_PWR_OFF),
                .ack_req(hit && op == OP_ACK_OC),
                .flag_lo(lo_sync[i]), .oc_lvl(oc_lvl[i]),
                .st(pst[i])
            );

            if (i == 0) begin : g_first
                assign vbus_en[i] = indiv_mode ? pst[i].pwr : hst.pwr;
            end else begin : g_rest
                assign vbus_en[i] = indiv_mode & pst[i].pwr;
            end

            assign status_change[i+1] = pst[i].oc_chg;

            // shutdown window watch: raw flag low while enable high
            logic [SCW-1:0] lo_run;
            always_ff @(posedge clk) begin
                if (rst || !vbus_en[i] || oc_flag_n[i]) lo_run <= '0;
                else if (lo_run != SCW'(SHUT_BOUND + 1)) lo_run <= lo_run + 1'b1;
            end
            // R6
            shutdown_bound_chk: assert property (@(posedge clk) disable iff (rst)
                lo_run <= SCW'(SHUT_BOUND));
        end
    endgenerate

    logic hub_act;
    assign hub_act = ~indiv_mode;

    hpp_port_ctrl u_hub (
        .clk(clk), .rst(rst), .act(hub_act),
        .set_req(req_valid && op == OP_PWR_ON),
        .clr_req(req_valid && op == OP_PWR_OFF),
        .ack_req(req_valid && op == OP_ACK_OC),
        .flag_lo(lo_sync[0]), .oc_lvl(oc_lvl[0]),
        .st(hst)
    );

    assign hub_oc_status    = hst.oc_st;
    assign hub_oc_change    = hst.oc_chg;
    assign status_change[0] = hst.oc_chg;

    always_comb begin
        port_state_t s;
        s = pst[rd_port];
        if (indiv_mode) begin
            rd_status = pack_status(s.pwr, s.oc_st);
            rd_change = pack_change(s.oc_chg);
        end else begin
            rd_status = pack_status(hst.pwr, 1'b0);
            rd_change = pack_change(1'b0);
        end
    end

    // R4
    shared_idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !indiv_mode |-> (vbus_en[NUM_PORTS-1:1] == '0));
endmodule

// File: tb/hub_port_power_tb.sv
module hub_port_power_tb;
    localparam int NP = 4;
    localparam int TD = 4;
    localparam int FL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic indiv_mode = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [1:0] req_port = 2'd0;
    logic [NP-1:0] oc_flag_n = '1;
    logic [NP-1:0] vbus_en;
    logic [1:0] rd_port = 2'd0;
    logic [15:0] rd_status, rd_change;
    logic hub_oc_status, hub_oc_change;
    logic [NP:0] status_change;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    hub_port_power #(.NUM_PORTS(NP), .TICK_DIV(TD), .FILT_LEN(FL)) u_dut (
        .clk(clk), .rst(rst), .indiv_mode(indiv_mode),
        .req_valid(req_valid), .req_op(req_op), .req_port(req_port),
        .oc_flag_n(oc_flag_n), .vbus_en(vbus_en),
        .rd_port(rd_port), .rd_status(rd_status), .rd_change(rd_change),
        .hub_oc_status(hub_oc_status), .hub_oc_change(hub_oc_change),
        .status_change(status_change)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input int p, input int op);
        @(negedge clk);
        req_valid = 1'b1; req_port = 2'(p); req_op = 2'(op);
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
    endtask

    task automatic rd(input int p);
        rd_port = 2'(p);
        #1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        indiv_mode = mode; rst = 1'b1; oc_flag_n = '1;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(1'b1);
        chk("R1 en", 32'(vbus_en), 32'h0);
        chk("R1 bitmap", 32'(status_change), 32'h0);
        for (int p = 0; p < NP; p++) begin
            rd(p);
            chk("R1 status", 32'(rd_status), 32'h0);
            chk("R1 change", 32'(rd_change), 32'h0);
        end

        // R2 R3 R11: sweep every power mask in per-port mode
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < NP; p++) cmd(p, 2);
            cmd(p_any(m), 0);
            for (int p = 0; p < NP; p++) if (m[p]) cmd(p, 1);
            chk("R2 R3 mask", 32'(vbus_en), 32'(m));
            for (int p = 0; p < NP; p++) begin
                rd(p);
                chk("R2 R11 status", 32'(rd_status), m[p] ? 32'h100 : 32'h0);
            end
        end

        // fault handling per port
        for (int p = 0; p < NP; p++) begin
            for (int q = 0; q < NP; q++) cmd(q, 1);
            // R5 short glitch
            @(negedge clk); oc_flag_n[p] = 1'b0;
            wait_n((FL - 1) * TD);
            oc_flag_n[p] = 1'b1;
            wait_n(6);
            chk("R5 glitch en", 32'(vbus_en), 32'hF);
            rd(p);
            chk("R5 glitch chg", 32'(rd_change), 32'h0);
            // R6 sustained fault
            @(negedge clk); oc_flag_n[p] = 1'b0;
            wait_n(2 + (FL - 1) * TD);
            chk("R6 early", 32'(vbus_en[p]), 32'h1);
            wait_n(FL * TD + 4 - (2 + (FL - 1) * TD));
            chk("R6 R3 late", 32'(vbus_en), 32'(4'hF & ~(4'h1 << p)));
            rd(p);
            chk("R7 status", 32'(rd_status), 32'h8);
            chk("R7 change", 32'(rd_change), 32'h8);
            chk("R7 bitmap", 32'(status_change), 32'(5'h1 << (p + 1)));
            rd((p + 1) % NP);
            chk("R3 other status", 32'(rd_status), 32'h100);
            // R9 power-on refused
            cmd(p, 1);
            chk("R9 refuse", 32'(vbus_en[p]), 32'h0);
            // R10 release
            oc_flag_n[p] = 1'b1;
            wait_n(6);
            rd(p);
            chk("R10 status clear", 32'(rd_status), 32'h0);
            chk("R10 change kept", 32'(rd_change), 32'h8);
            cmd((p + 1) % NP, 3);
            rd(p);
            chk("R10 wrong ack", 32'(rd_change), 32'h8);
            cmd(p, 3);
            rd(p);
            chk("R10 ack", 32'(rd_change), 32'h0);
            chk("R10 bitmap", 32'(status_change), 32'h0);
            cmd(p, 1);
            chk("R2 repower", 32'(vbus_en), 32'hF);
        end

        // shared mode
        do_reset(1'b0);
        chk("R1 shared", 32'(vbus_en), 32'h0);
        for (int p = 0; p < NP; p++) begin
            cmd(p, 1);
            chk("R4 on", 32'(vbus_en), 32'h1);
            cmd(p, 2);
            chk("R4 off", 32'(vbus_en), 32'h0);
        end
        cmd(2, 1);
        @(negedge clk); oc_flag_n[NP-1:1] = '0;
        wait_n(FL * TD + 10);
        chk("R4 ignored flags", 32'(vbus_en), 32'h1);
        chk("R4 ignored bitmap", 32'(status_change), 32'h0);
        oc_flag_n[NP-1:1] = '1;
        @(negedge clk); oc_flag_n[0] = 1'b0;
        wait_n(FL * TD + 4);
        chk("R6 shared late", 32'(vbus_en), 32'h0);
        chk("R8 hub status", 32'(hub_oc_status), 32'h1);
        chk("R8 hub change", 32'(hub_oc_change), 32'h1);
        chk("R8 bitmap", 32'(status_change), 32'h1);
        for (int p = 0; p < NP; p++) begin
            rd(p);
            chk("R8 port status", 32'(rd_status), 32'h0);
            chk("R8 port change", 32'(rd_change), 32'h0);
        end
        oc_flag_n[0] = 1'b1;
        wait_n(6);
        chk("R10 hub status clear", 32'(hub_oc_status), 32'h0);
        chk("R10 hub change kept", 32'(hub_oc_change), 32'h1);
        cmd(3, 3);
        chk("R10 hub ack", 32'(hub_oc_change), 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic int p_any(input int m);
        return m % NP;
    endfunction
endmodule